// File: doc/BRIEF.md
# Receive Character Queue with Error Tags

This block buffers characters coming out of a serial receiver until the host collects them. Each arriving character is stored with three tag bits: break seen, framing error and parity error. The queue has a small number of slots plus one extra holding stage. A character that arrives while every slot is taken waits in the holding stage. The block builds the eight-bit status byte that the host reads, and it drives the data-present flag, the queue-full flag, the overrun flag and a receive interrupt whose trigger can be selected.

The error tags can be reported in one of two ways. In per-character reporting, the status byte shows the tags of the character at the head of the queue, so they change as characters are removed. In accumulate reporting, the status byte shows the OR of the tags of every character that arrived since the last clear, and those bits hold until the host issues an error-clear command or a receiver reset.

Top module: `rx_tag_fifo`

## Requirements
- R1: Characters leave in arrival order. `head_data` shows the oldest stored character whenever `rx_ready` is 1, and each character keeps the three tags it arrived with.
- R2: `rx_ready` is 1 when at least one queue slot holds a character. `fifo_full` is 1 when all DEPTH slots are occupied.
- R3: A character that arrives while all slots are occupied is kept in the holding stage. It moves into the queue on the next pop, in order behind the others, and nothing is lost.
- R4: If a character arrives while the slots and the holding stage are all occupied, and no pop happens in that cycle, the overrun flag (status bit 4) is set. The new character replaces the one in the holding stage, and the queue slots do not change.
- R5: When an arrival and a pop fall in the same cycle, both take effect at any occupancy, and no overrun is raised.
- R6: The status byte layout is: bit 7 break, bit 6 framing error, bit 5 parity error, bit 4 overrun, bit 3 the `tx_empty` input, bit 2 the `tx_ready` input, bit 1 `fifo_full`, bit 0 `rx_ready`.
- R7: With `err_block_mode`=0, status bits 7:5 are the tags of the head character, or 0 when the queue is empty. They change when that character is popped.
- R8: With `err_block_mode`=1, status bits 7:5 are the OR of the tags of every arriving character since the last clear, including a character that was later overwritten. Each bit stays set until a clear.
- R9: `cmd_err_rst` clears the overrun flag and the accumulated tags. A character arriving in the same cycle contributes its tags, and any overrun it causes, to the new state.
- R10: `cmd_rx_rst` empties the queue and the holding stage and clears the ready, full, overrun and tag state in one cycle. It overrides any arrival, pop or error clear in the same cycle.
- R11: With `irq_on_full`=0, `rx_irq` follows `rx_ready`. With `irq_on_full`=1, it follows `fifo_full`.
- R12: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_wr | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | DATA_W | Received character |
| rx_brk | input | 1 | Break tag of the received character |
| rx_fe | input | 1 | Framing-error tag of the received character |
| rx_pe | input | 1 | Parity-error tag of the received character |
| host_pop | input | 1 | Host removes the head character |
| err_block_mode | input | 1 | 0 = per-character tags, 1 = accumulated tags |
| irq_on_full | input | 1 | Interrupt trigger select: 0 = data present, 1 = full |
| cmd_err_rst | input | 1 | Error-clear command strobe |
| cmd_rx_rst | input | 1 | Receiver reset command strobe |
| tx_empty | input | 1 | Transmitter-empty bit, passed through into status |
| tx_ready | input | 1 | Transmitter-ready bit, passed through into status |
| head_data | output | DATA_W | Oldest stored character |
| status | output | 8 | Status byte |
| rx_ready | output | 1 | At least one character stored |
| fifo_full | output | 1 | All queue slots occupied |
| overrun | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Two pairs of actions can land in the same clock edge: an arrival together with a pop, and an error clear together with an arrival. The bench starts from every occupancy, from empty up to a full holding stage, and applies every mix of arrival, pop, error clear and receiver reset in a single cycle, in both tag-reporting modes. It judges each result against a queue model kept in the bench. After that cycle it drains the queue, checking order, tags and flags at every step.

// File: rtl/rxtf_pkg.sv
// Package: shared types and bit positions for the receive tag queue.
// Assumes an 8-bit status byte that the host register decoder reads as-is.
package rxtf_pkg;
    // Per-character error tags.
    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } tag_t;

    localparam int TAG_W     = 3;
    localparam int STAT_W    = 8;
    localparam int ST_OVR    = 4;
    localparam int ST_TXEMT  = 3;
    localparam int ST_TXRDY  = 2;
    localparam int ST_FULL   = 1;
    localparam int ST_READY  = 0;
endpackage

// File: rtl/rxtf_store.sv
// Module: circular character queue of DEPTH slots plus one holding stage.
// An arrival while the slots are full parks in the holding stage. An
// arrival while the holding stage is also full, with no pop, overwrites it
// and flags an overrun event. Assumes the caller's clr overrides all else.
module rxtf_store #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 3,
    localparam int ENT_W  = DATA_W + rxtf_pkg::TAG_W,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic             pop_req,
    output logic [ENT_W-1:0] head_ent,
    output logic [CNT_W-1:0] cnt,
    output logic             hold_vld,
    output logic             ovr_evt
);
    logic [ENT_W-1:0] mem [DEPTH];
    logic [ENT_W-1:0] hold_q;
    logic             hold_q_vld;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             is_full;
    logic             do_pop;
    logic             fifo_push;
    logic             hold_load;
    logic [ENT_W-1:0] push_ent;

    // Advance a slot pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Decide where an arrival goes and whether the holding stage drains.
    always_comb begin
        is_full   = (cnt_q == CNT_W'(DEPTH));
        do_pop    = pop_req && (cnt_q != '0);
        fifo_push = hold_q_vld ? do_pop : (wr_en && (!is_full || do_pop));
        push_ent  = hold_q_vld ? hold_q : wr_ent;
        hold_load = wr_en && (hold_q_vld || (is_full && !do_pop));
        ovr_evt   = wr_en && hold_q_vld && !do_pop;
    end

    // Slot storage: write the pushed entry at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (fifo_push && !clr) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    // Pointers, occupancy and holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr     <= '0;
            wr_ptr     <= '0;
            cnt_q      <= '0;
            hold_q     <= '0;
            hold_q_vld <= 1'b0;
        end else begin
            if (fifo_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)    rd_ptr <= bump(rd_ptr);
            case ({fifo_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (hold_load) begin
                hold_q     <= wr_ent;
                hold_q_vld <= 1'b1;
            end else if (hold_q_vld && do_pop) begin
                hold_q_vld <= 1'b0;
            end
        end
    end

    assign head_ent = mem[rd_ptr];
    assign cnt      = cnt_q;
    assign hold_vld = hold_q_vld;
endmodule

// File: rtl/rxtf_errs.sv
// Module: accumulated error tags and the overrun flag.
// The tags of every arrival are ORed in. An error clear drops the old state
// but still takes in the same cycle's arrival. clr (receiver reset) wins.
module rxtf_errs (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           err_rst,
    input  logic           wr_en,
    input  rxtf_pkg::tag_t wr_tags,
    input  logic           ovr_evt,
    output rxtf_pkg::tag_t sticky,
    output logic           ovr
);
    logic [rxtf_pkg::TAG_W-1:0] acc_q;
    logic [rxtf_pkg::TAG_W-1:0] acc_keep;
    logic [rxtf_pkg::TAG_W-1:0] acc_new;
    logic                       ovr_q;

    // Old state kept unless cleared; new arrival tags always folded in.
    always_comb begin
        acc_keep = err_rst ? '0 : acc_q;
        acc_new  = wr_en ? wr_tags : '0;
    end

    // Update the accumulated tags and the overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            acc_q <= acc_keep | acc_new;
            ovr_q <= (err_rst ? 1'b0 : ovr_q) | ovr_evt;
        end
    end

    assign sticky = rxtf_pkg::tag_t'(acc_q);
    assign ovr    = ovr_q;
endmodule

// File: rtl/rxtf_status.sv
// Module: builds the host status byte, the flags and the receive interrupt.
// Purely combinational. Assumes cnt counts occupied slots only, not the
// holding stage.
module rxtf_status #(
    parameter  int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             err_block_mode,
    input  logic             irq_on_full,
    input  logic [CNT_W-1:0] cnt,
    input  rxtf_pkg::tag_t   head_tags,
    input  rxtf_pkg::tag_t   sticky,
    input  logic             ovr,
    input  logic             tx_empty,
    input  logic             tx_ready,
    output logic [7:0]       status,
    output logic             ready,
    output logic             full,
    output logic             irq
);
    rxtf_pkg::tag_t shown;

    // Pick the tag source and assemble the status byte.
    always_comb begin
        ready = (cnt != '0);
        full  = (cnt == CNT_W'(DEPTH));
        if (err_block_mode)  shown = sticky;
        else if (ready)      shown = head_tags;
        else                 shown = '0;
        status                     = '0;
        status[7:5]                = shown;
        status[rxtf_pkg::ST_OVR]   = ovr;
        status[rxtf_pkg::ST_TXEMT] = tx_empty;
        status[rxtf_pkg::ST_TXRDY] = tx_ready;
        status[rxtf_pkg::ST_FULL]  = full;
        status[rxtf_pkg::ST_READY] = ready;
        irq = irq_on_full ? full : ready;
    end
endmodule

// File: rtl/rx_tag_fifo.sv
// Module: receive character queue with per-character error tags (top).
// Ties the slot store, the error tracker and the status builder together.
// Assumes strobes are single-cycle and synchronous to clk.
module rx_tag_fifo #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 3,
    localparam int ENT_W  = DATA_W + rxtf_pkg::TAG_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_wr,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_brk,
    input  logic              rx_fe,
    input  logic              rx_pe,
    input  logic              host_pop,
    input  logic              err_block_mode,
    input  logic              irq_on_full,
    input  logic              cmd_err_rst,
    input  logic              cmd_rx_rst,
    input  logic              tx_empty,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] head_data,
    output logic [7:0]        status,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              overrun,
    output logic              rx_irq
);
    rxtf_pkg::tag_t   wr_tags;
    rxtf_pkg::tag_t   head_tags;
    rxtf_pkg::tag_t   sticky;
    logic [ENT_W-1:0] wr_ent;
    logic [ENT_W-1:0] head_ent;
    logic [CNT_W-1:0] cnt;
    logic             hold_vld;
    logic             ovr_evt;
    logic             ovr;

    // Pack the incoming tags with the character.
    always_comb begin
        wr_tags.brk = rx_brk;
        wr_tags.fe  = rx_fe;
        wr_tags.pe  = rx_pe;
        wr_ent      = {wr_tags, rx_data};
        head_tags   = rxtf_pkg::tag_t'(head_ent[ENT_W-1 -: rxtf_pkg::TAG_W]);
        head_data   = head_ent[DATA_W-1:0];
    end

    rxtf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_rx_rst),
        .wr_en    (rx_wr),
        .wr_ent   (wr_ent),
        .pop_req  (host_pop),
        .head_ent (head_ent),
        .cnt      (cnt),
        .hold_vld (hold_vld),
        .ovr_evt  (ovr_evt)
    );

    rxtf_errs u_errs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_rx_rst),
        .err_rst (cmd_err_rst),
        .wr_en   (rx_wr),
        .wr_tags (wr_tags),
        .ovr_evt (ovr_evt),
        .sticky  (sticky),
        .ovr     (ovr)
    );

    rxtf_status #(.DEPTH(DEPTH)) u_status (
        .err_block_mode (err_block_mode),
        .irq_on_full    (irq_on_full),
        .cnt            (cnt),
        .head_tags      (head_tags),
        .sticky         (sticky),
        .ovr            (ovr),
        .tx_empty       (tx_empty),
        .tx_ready       (tx_ready),
        .status         (status),
        .ready          (rx_ready),
        .full           (fifo_full),
        .irq            (rx_irq)
    );

    assign overrun = ovr;
endmodule

// File: rtl/rxtf_checker.sv
// Module: temporal checks on the receive tag queue, bound to the top.
// Assumes the bound instance exposes its holding-stage valid signal.
module rxtf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_wr,
    input logic       host_pop,
    input logic       cmd_err_rst,
    input logic       cmd_rx_rst,
    input logic       err_block_mode,
    input logic       hold_vld,
    input logic [7:0] status,
    input logic       rx_ready,
    input logic       fifo_full,
    input logic       overrun
);
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> rx_ready); // R2
    AST_HOLD_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hold_vld |-> fifo_full); // R3
    AST_OVR_ON_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && hold_vld && !host_pop && !cmd_rx_rst) |=> overrun); // R4
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_block_mode && $past(err_block_mode) && $past(status[7])
         && !$past(cmd_err_rst) && !$past(cmd_rx_rst)) |-> status[7]); // R8
    AST_ERR_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err_rst && !rx_wr) |=> !overrun); // R9
    AST_RX_RST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_rst |=> (!rx_ready && !fifo_full && !overrun && !hold_vld
                        && status[7:5] == 3'b000)); // R10
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !rx_wr) |=> !rx_ready); // R12
endmodule

bind rx_tag_fifo rxtf_checker u_rxtf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_wr          (rx_wr),
    .host_pop       (host_pop),
    .cmd_err_rst    (cmd_err_rst),
    .cmd_rx_rst     (cmd_rx_rst),
    .err_block_mode (err_block_mode),
    .hold_vld       (hold_vld),
    .status         (status),
    .rx_ready       (rx_ready),
    .fifo_full      (fifo_full),
    .overrun        (overrun)
);

// File: tb/rx_tag_fifo_bench.sv
// Bench: sweeps every starting occupancy against every single-cycle mix of
// arrival, pop, error clear and receiver reset in both tag modes, and
// compares each cycle with a queue model kept in the bench.
module rx_tag_fifo_bench;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 3;
    localparam int QMAX   = DEPTH + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rx_wr, rx_brk, rx_fe, rx_pe, host_pop;
    logic [DATA_W-1:0] rx_data;
    logic              err_block_mode, irq_on_full, cmd_err_rst, cmd_rx_rst;
    logic              tx_empty, tx_ready;
    logic [DATA_W-1:0] head_data;
    logic [7:0]        status;
    logic              rx_ready, fifo_full, overrun, rx_irq;

    always #5 clk = ~clk;

    rx_tag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_tag_fifo (
        .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_fe(rx_fe), .rx_pe(rx_pe), .host_pop(host_pop),
        .err_block_mode(err_block_mode), .irq_on_full(irq_on_full),
        .cmd_err_rst(cmd_err_rst), .cmd_rx_rst(cmd_rx_rst),
        .tx_empty(tx_empty), .tx_ready(tx_ready), .head_data(head_data),
        .status(status), .rx_ready(rx_ready), .fifo_full(fifo_full),
        .overrun(overrun), .rx_irq(rx_irq)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    string       ctx;
    logic [DATA_W-1:0] md [QMAX];
    logic [2:0]  mt [QMAX];
    int          mq;
    logic [2:0]  msticky;
    logic        movr;
    int          seq = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
        end
    endtask

    task automatic compare();
        logic       er, ef;
        logic [2:0] shown;
        logic [7:0] es;
        er    = (mq > 0);
        ef    = (mq >= DEPTH);
        shown = err_block_mode ? msticky : (er ? mt[0] : 3'b000);
        es    = {shown, movr, tx_empty, tx_ready, ef, er};
        chk("R2 rx_ready", int'(rx_ready), int'(er));
        chk("R2 fifo_full", int'(fifo_full), int'(ef));
        if (err_block_mode) chk("R8 accumulated tags", int'(status[7:5]), int'(shown));
        else                chk("R7 head tags", int'(status[7:5]), int'(shown));
        chk("R4 overrun", int'(overrun), int'(movr));
        chk("R6 status byte", int'(status), int'(es));
        chk("R11 rx_irq", int'(rx_irq), int'(irq_on_full ? ef : er));
        if (er) chk("R1 head_data", int'(head_data), int'(md[0]));
    endtask

    task automatic model_step(input logic w, input logic [2:0] tg,
                              input logic [DATA_W-1:0] d, input logic p,
                              input logic e, input logic r);
        logic dp;
        if (r) begin
            mq = 0; msticky = 3'b000; movr = 1'b0;
        end else begin
            dp = p && (mq > 0);
            if (e) begin msticky = 3'b000; movr = 1'b0; end
            if (w) msticky = msticky | tg;
            if (w && mq == QMAX && !dp) movr = 1'b1;
            if (dp) begin
                for (int i = 0; i < QMAX - 1; i++) begin
                    md[i] = md[i+1]; mt[i] = mt[i+1];
                end
                mq--;
            end
            if (w) begin
                if (mq == QMAX) begin
                    md[QMAX-1] = d; mt[QMAX-1] = tg;
                end else begin
                    md[mq] = d; mt[mq] = tg; mq++;
                end
            end
        end
    endtask

    task automatic op(input logic w, input logic [2:0] tg, input logic p,
                      input logic e, input logic r);
        logic [DATA_W-1:0] d;
        d = DATA_W'(seq * 37 + 11);
        seq++;
        rx_wr = w; {rx_brk, rx_fe, rx_pe} = tg; rx_data = d;
        host_pop = p; cmd_err_rst = e; cmd_rx_rst = r;
        @(posedge clk);
        #2;
        model_step(w, tg, d, p, e, r);
        rx_wr = 1'b0; host_pop = 1'b0; cmd_err_rst = 1'b0; cmd_rx_rst = 1'b0;
        compare();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_wr = 1'b0; rx_data = '0; rx_brk = 1'b0; rx_fe = 1'b0;
        rx_pe = 1'b0; host_pop = 1'b0; err_block_mode = 1'b0; irq_on_full = 1'b0;
        cmd_err_rst = 1'b0; cmd_rx_rst = 1'b0; tx_empty = 1'b0; tx_ready = 1'b0;
        mq = 0; msticky = 3'b000; movr = 1'b0;
        for (int i = 0; i < QMAX; i++) begin md[i] = '0; mt[i] = '0; end
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        ctx = "R10 reset state";
        compare();
        for (int mode = 0; mode < 2; mode++) begin
            for (int occ = 0; occ <= QMAX; occ++) begin
                for (int sel = 0; sel < 16; sel++) begin
                    for (int tp = 0; tp < 8; tp++) begin
                        logic w, p, e, r;
                        w = sel[0]; p = sel[1]; e = sel[2]; r = sel[3];
                        err_block_mode = mode[0];
                        irq_on_full    = tp[0];
                        tx_empty       = tp[1];
                        tx_ready       = tp[2];
                        ctx = "R10 clear";
                        op(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
                        for (int i = 0; i < occ; i++) begin
                            ctx = (i >= DEPTH) ? "R3 fill hold" : "R1 fill";
                            op(1'b1, 3'((tp + i * 3) & 7), 1'b0, 1'b0, 1'b0);
                        end
                        if (r)                       ctx = "R10 reset mix";
                        else if (e)                  ctx = "R9 clear mix";
                        else if (w && p)             ctx = "R5 push and pop";
                        else if (p && occ == 0)      ctx = "R12 empty pop";
                        else if (w && occ == QMAX)   ctx = "R4 spill";
                        else if (w && occ >= DEPTH)  ctx = "R3 park";
                        else if (mode == 1)          ctx = "R8 accumulate";
                        else                         ctx = "R7 per char";
                        op(w, 3'((tp * 5 + 1) & 7), p, e, r);
                        ctx = mode[0] ? "R8 drain" : "R3 drain";
                        for (int k = 0; k < QMAX + 1 && mq > 0; k++) begin
                            op(1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
                        end
                        ctx = "R12 pop when empty";
                        op(1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
                    end
                end
            end
        end
        summary();
        $finish;
    end
endmodule